// File: doc/BRIEF.md
# TDM Time-Slot Channel Assigner

This block places two 8-bit bearer channels and one 2-bit signalling channel onto a serial time-division-multiplexed port. It also pulls the same three channels back off that port. The port runs on a bit clock. A frame-sync pulse starts each 512-bit frame, which is split into 64 slots of 8 bits. The signalling channel uses a finer grid of 256 sub-slots of 2 bits each.

Each direction has its own assignment registers. On the transmit side (serial port towards the line), each bearer channel has a register holding an enable bit and a slot number, and the signalling channel has a sub-slot register. The receive side (line towards serial port) has the same set. A simple parallel write port loads the registers. A new setting waits in a shadow copy and takes effect at the next frame boundary. On the line side, data appears as parallel words with one-cycle valid strobes. Words to be sent out arrive as parallel inputs that the block captures at each frame start.

The block runs entirely on the bit clock. The serial input is sampled on the falling edge, and the serial output and its drive enable change on the rising edge. A drive enable of 0 stands for a high-impedance pad. The signalling channel is enabled per direction through two control inputs.

Top module: `tdm_slot_mapper`

## Requirements
- R1: A frameSync sampled high at a rising edge makes that bit period bit 0, even in the middle of a frame. Without frameSync, the bit count wraps from 511 to 0. Bearer slot s covers bits 8s..8s+7 and sub-slot n covers bits 2n and 2n+1. Bits travel MSB first.
- R2: Each enabled transmit bearer channel outputs the 8 serial bits of its slot as a word (first bit in bit 7), with a one-cycle valid strobe in the bit period right after the slot's last bit.
- R3: A disabled transmit bearer channel still strobes at the end of its slot, but its word is 8'hFF.
- R4: The transmit signalling channel outputs the 2 bits of its sub-slot, with a one-cycle strobe after the sub-slot. When txDEnable is 0, its word is 2'b11.
- R5: During its slot, an enabled receive bearer channel sets serOutEn to 1 and drives its line word MSB first on serOutData. Line words are captured at the first bit of each frame.
- R6: Outside every enabled receive slot, serOutEn is 0 (high impedance), and this includes the slots of disabled channels. After reset, all channels are disabled and serOutEn is 0.
- R7: slotActiveN is 0 exactly in the bit periods where an enabled receive bearer channel drives the port. A signalling sub-slot does not pull it low.
- R8: When rxDEnable is 1, the receive signalling channel drives lineRxD MSB first during its sub-slot, with serOutEn high.
- R9: Bearer register format: bit 7 is the enable, bits 5..0 are the slot number, and bit 6 has no effect. Signalling registers hold the 8-bit sub-slot number.
- R10: Register addresses are 0 transmit B1, 1 transmit B2, 2 receive B1, 3 receive B2, 4 transmit D, 5 receive D. A write takes effect at the first frame boundary after it, so the frame in progress keeps the old setting.
- R11: If both bearer channels share a slot, both transmit words carry that slot's data, and on the receive side B1 drives the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameSync | input | 1 | Frame start marker, sampled on rising edge |
| serIn | input | 1 | Serial port data in, sampled on falling edge |
| serOutData | output | 1 | Serial port data out |
| serOutEn | output | 1 | Pad drive enable; 0 means high impedance |
| slotActiveN | output | 1 | Low while an enabled receive bearer slot is driven |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| txDEnable | input | 1 | Transmit signalling channel enable |
| rxDEnable | input | 1 | Receive signalling channel enable |
| lineRxB1 | input | 8 | Line word for receive B1 |
| lineRxB2 | input | 8 | Line word for receive B2 |
| lineRxD | input | 2 | Line word for receive D |
| txB1Data | output | 8 | Word extracted for transmit B1 |
| txB1Valid | output | 1 | Strobe for txB1Data |
| txB2Data | output | 8 | Word extracted for transmit B2 |
| txB2Valid | output | 1 | Strobe for txB2Data |
| txDData | output | 2 | Word extracted for transmit D |
| txDValid | output | 1 | Strobe for txDData |

## Verification
The bench uses the default geometry of 64 slots of 8 bits and 2-bit sub-slots, so one frame is only 512 bit clocks. A single run can therefore cover more than a dozen whole frames and record every bit period of each one. This brings the last slot within reach, which wraps its strobe into the next frame, as well as a high sub-slot, deferred register updates across a boundary, and a frame that is cut short by an early sync.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int SLOT_BITS  = 8;
  localparam int NUM_SLOTS  = 64;
  localparam int SUB_BITS   = 2;
  localparam int NUM_B      = 2;
  localparam int REG_W      = 8;
  localparam int EN_BIT     = 7;
  localparam int NUM_REGS   = 2 * NUM_B + 2;
  localparam int ADDR_W     = 3;
  localparam int FRAME_BITS = SLOT_BITS * NUM_SLOTS;
  localparam int FRAME_W    = $clog2(FRAME_BITS);
  localparam int SLOT_LSB   = $clog2(SLOT_BITS);
  localparam int SUB_LSB    = $clog2(SUB_BITS);
  localparam int SLOT_W     = FRAME_W - SLOT_LSB;
  localparam int SUB_W      = FRAME_W - SUB_LSB;

  // register map: transmit bearers, receive bearers, then signalling pair
  localparam int IDX_TX_B = 0;
  localparam int IDX_RX_B = NUM_B;
  localparam int IDX_TX_D = 2 * NUM_B;
  localparam int IDX_RX_D = 2 * NUM_B + 1;

  typedef struct packed {
    logic                 frameStart;
    logic [NUM_B-1:0]     txBHit;
    logic [NUM_B-1:0]     txBOn;
    logic                 txDHit;
    logic                 txDOn;
    logic [NUM_B-1:0]     rxBDrive;
    logic                 rxDDrive;
    logic [SLOT_LSB-1:0]  bitInSlot;
    logic [SUB_LSB-1:0]   bitInSub;
  } slot_ctl_t;
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              txDEnable,
  input  logic              rxDEnable,
  output slot_ctl_t         ctl
);
  logic [FRAME_W-1:0] bitCnt, curBit;
  logic [NUM_REGS-1:0][REG_W-1:0] shadowReg, activeReg, effReg;
  logic frameStart;
  logic [SLOT_W-1:0] curSlot;
  logic [SUB_W-1:0]  curSub;
  logic [NUM_B-1:0]  txHitV, txOnV, rxDrvV;

  assign curBit     = frameSync ? '0 : bitCnt;
  assign frameStart = (curBit == '0);
  assign curSlot    = curBit[FRAME_W-1:SLOT_LSB];
  assign curSub     = curBit[FRAME_W-1:SUB_LSB];
  // settings written before a boundary are seen from its first bit
  assign effReg     = frameStart ? shadowReg : activeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shadowReg <= '0;
      activeReg <= '0;
    end else begin
      bitCnt <= (curBit == FRAME_W'(FRAME_BITS - 1)) ? '0 : curBit + 1'b1;
      if (wrEn && (wrAddr < ADDR_W'(NUM_REGS)))
        shadowReg[wrAddr] <= wrData;
      if (frameStart)
        activeReg <= shadowReg;
    end
  end

  for (genvar b = 0; b < NUM_B; b++) begin : g_bslot
    assign txHitV[b] = (effReg[IDX_TX_B + b][SLOT_W-1:0] == curSlot);
    assign txOnV[b]  = effReg[IDX_TX_B + b][EN_BIT];
    assign rxDrvV[b] = effReg[IDX_RX_B + b][EN_BIT] &&
                       (effReg[IDX_RX_B + b][SLOT_W-1:0] == curSlot);
  end

  always_comb begin
    ctl            = '0;
    ctl.frameStart = frameStart;
    ctl.txBHit     = txHitV;
    ctl.txBOn      = txOnV;
    ctl.rxBDrive   = rxDrvV;
    ctl.txDHit     = (effReg[IDX_TX_D][SUB_W-1:0] == curSub);
    ctl.txDOn      = txDEnable;
    ctl.rxDDrive   = rxDEnable && (effReg[IDX_RX_D][SUB_W-1:0] == curSub);
    ctl.bitInSlot  = curBit[SLOT_LSB-1:0];
    ctl.bitInSub   = curBit[SUB_LSB-1:0];
  end

  // R1: a sync restarts counting, so the following period is bit 1
  p_sync_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (bitCnt == FRAME_W'(1)));

  // R10: live settings only change on a frame boundary
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeReg));
endmodule

// File: rtl/tdm_slot_datapath.sv
module tdm_slot_datapath
  import tdm_slot_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  slot_ctl_t                         ctl,
  input  logic                              serIn,
  input  logic [NUM_B-1:0][SLOT_BITS-1:0]   lineRxB,
  input  logic [SUB_BITS-1:0]               lineRxD,
  output logic [NUM_B-1:0][SLOT_BITS-1:0]   txBData,
  output logic [NUM_B-1:0]                  txBValid,
  output logic [SUB_BITS-1:0]               txDData,
  output logic                              txDValid,
  output logic                              serOutData,
  output logic                              serOutEn,
  output logic                              slotActiveN
);
  // ---------------- receive: line words onto the serial port ----------------
  logic [NUM_B-1:0][SLOT_BITS-1:0] lineBQ, effB;
  logic [SUB_BITS-1:0] lineDQ, effD;
  logic [NUM_B-1:0] rxBit;
  logic dBit, driveBit;

  assign effB = ctl.frameStart ? lineRxB : lineBQ;
  assign effD = ctl.frameStart ? lineRxD : lineDQ;
  assign dBit = effD[~ctl.bitInSub];

  for (genvar b = 0; b < NUM_B; b++) begin : g_rxbit
    assign rxBit[b] = effB[b][~ctl.bitInSlot];
  end

  always_comb begin
    driveBit = 1'b1;
    if (ctl.rxDDrive) driveBit = dBit;
    // descending so the lowest-numbered bearer wins a shared slot
    for (int b = NUM_B - 1; b >= 0; b--)
      if (ctl.rxBDrive[b]) driveBit = rxBit[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineBQ      <= '0;
      lineDQ      <= '0;
      serOutEn    <= 1'b0;
      serOutData  <= 1'b1;
      slotActiveN <= 1'b1;
    end else begin
      if (ctl.frameStart) begin
        lineBQ <= lineRxB;
        lineDQ <= lineRxD;
      end
      serOutEn    <= (|ctl.rxBDrive) || ctl.rxDDrive;
      serOutData  <= driveBit;
      slotActiveN <= ~(|ctl.rxBDrive);
    end
  end

  // ---------------- transmit: serial port words to the line ----------------
  logic sampledBit;
  logic [NUM_B-1:0] hitQ, onQ;
  logic dHitQ, dOnQ;
  logic [SLOT_LSB-1:0] bitQ;
  logic [SUB_LSB-1:0] subQ;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) sampledBit <= 1'b1;
    else       sampledBit <= serIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ <= '0; onQ <= '0; dHitQ <= 1'b0; dOnQ <= 1'b0;
      bitQ <= '0; subQ <= '0;
    end else begin
      hitQ <= ctl.txBHit; onQ <= ctl.txBOn;
      dHitQ <= ctl.txDHit; dOnQ <= ctl.txDOn;
      bitQ <= ctl.bitInSlot; subQ <= ctl.bitInSub;
    end
  end

  for (genvar b = 0; b < NUM_B; b++) begin : g_txb
    logic [SLOT_BITS-1:0] shReg, wordQ;
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg <= '0; wordQ <= '1; validQ <= 1'b0;
      end else begin
        validQ <= 1'b0;
        if (hitQ[b]) begin
          shReg <= {shReg[SLOT_BITS-2:0], sampledBit};
          if (&bitQ) begin
            validQ <= 1'b1;
            wordQ  <= onQ[b] ? {shReg[SLOT_BITS-2:0], sampledBit} : '1;
          end
        end
      end
    end
    assign txBData[b]  = wordQ;
    assign txBValid[b] = validQ;

    // R2: slots are 8 bits long, so a strobe never repeats back to back
    p_bvalid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
      validQ |=> !validQ);
  end

  logic [SUB_BITS-1:0] dSh;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dSh <= '0; txDData <= '1; txDValid <= 1'b0;
    end else begin
      txDValid <= 1'b0;
      if (dHitQ) begin
        dSh <= {dSh[SUB_BITS-2:0], sampledBit};
        if (&subQ) begin
          txDValid <= 1'b1;
          txDData  <= dOnQ ? {dSh[SUB_BITS-2:0], sampledBit} : '1;
        end
      end
    end
  end

  // R4: a sub-slot is two bits, strobes are isolated pulses
  p_dvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    txDValid |=> !txDValid);

  // R7: the slot-active indicator only appears while the pad is driven
  p_active_driven_r7: assert property (@(posedge clk) disable iff (!rstN)
    !slotActiveN |-> serOutEn);
endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
  import tdm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              serIn,
  output logic              serOutData,
  output logic              serOutEn,
  output logic              slotActiveN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              txDEnable,
  input  logic              rxDEnable,
  input  logic [SLOT_BITS-1:0] lineRxB1,
  input  logic [SLOT_BITS-1:0] lineRxB2,
  input  logic [SUB_BITS-1:0]  lineRxD,
  output logic [SLOT_BITS-1:0] txB1Data,
  output logic              txB1Valid,
  output logic [SLOT_BITS-1:0] txB2Data,
  output logic              txB2Valid,
  output logic [SUB_BITS-1:0]  txDData,
  output logic              txDValid
);
  slot_ctl_t ctl;
  logic [NUM_B-1:0][SLOT_BITS-1:0] txBData;
  logic [NUM_B-1:0] txBValid;

  tdm_slot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txDEnable(txDEnable), .rxDEnable(rxDEnable), .ctl(ctl)
  );

  tdm_slot_datapath u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .serIn(serIn),
    .lineRxB({lineRxB2, lineRxB1}), .lineRxD(lineRxD),
    .txBData(txBData), .txBValid(txBValid),
    .txDData(txDData), .txDValid(txDValid),
    .serOutData(serOutData), .serOutEn(serOutEn), .slotActiveN(slotActiveN)
  );

  assign txB1Data  = txBData[0];
  assign txB1Valid = txBValid[0];
  assign txB2Data  = txBData[1];
  assign txB2Valid = txBValid[1];
endmodule

// File: tb/tdm_slot_mapper_bench.sv
`timescale 1ns/1ps
module tdm_slot_mapper_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, frameSync = 1'b0, serIn = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic txDEnable = 1'b0, rxDEnable = 1'b0;
  logic [7:0] lineRxB1 = 8'hA5, lineRxB2 = 8'h3C;
  logic [1:0] lineRxD = 2'b10;
  logic serOutData, serOutEn, slotActiveN;
  logic [7:0] txB1Data, txB2Data;
  logic [1:0] txDData;
  logic txB1Valid, txB2Valid, txDValid;

  tdm_slot_mapper u_tdm_slot_mapper (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .serIn(serIn),
    .serOutData(serOutData), .serOutEn(serOutEn), .slotActiveN(slotActiveN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txDEnable(txDEnable), .rxDEnable(rxDEnable),
    .lineRxB1(lineRxB1), .lineRxB2(lineRxB2), .lineRxD(lineRxD),
    .txB1Data(txB1Data), .txB1Valid(txB1Valid),
    .txB2Data(txB2Data), .txB2Valid(txB2Valid),
    .txDData(txDData), .txDValid(txDValid)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(input int f, input int s);
    return 8'((s * 37 + f * 11 + 5) % 256);
  endfunction
  function automatic logic patBit(input int f, input int k);
    logic [7:0] v;
    v = patByte(f, k / 8);
    return v[7 - (k % 8)];
  endfunction

  // ---------------- serial driver ----------------
  int idx = 400, frameCnt = 0, curIdx = -1, curFrame = -1;
  bit run = 0, jumpReq = 0;
  initial begin
    wait (run);
    forever begin
      @(negedge clk);
      if (jumpReq && idx == 200) begin
        idx = 0; frameCnt++; jumpReq = 0;
      end
      frameSync = (idx == 0);
      @(posedge clk); #1;
      curIdx = idx; curFrame = frameCnt;
      serIn = patBit(frameCnt, idx);
      idx++;
      if (idx == 512) begin idx = 0; frameCnt++; end
    end
  end

  // ---------------- monitor ----------------
  bit capEn[512], capD[512], capA[512];
  bit doneEn[512], doneD[512], doneA[512];
  int doneFrame = -1, nB1 = 0, nB2 = 0, nD = 0;
  logic [7:0] lastB1 = '0, lastB2 = '0;
  logic [1:0] lastD = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (curIdx >= 0) begin
        capEn[curIdx] = serOutEn; capD[curIdx] = serOutData; capA[curIdx] = slotActiveN;
        if (curIdx == 511) begin
          doneEn = capEn; doneD = capD; doneA = capA; doneFrame = curFrame;
        end
      end
      if (txB1Valid) begin lastB1 = txB1Data; nB1++; end
      if (txB2Valid) begin lastB2 = txB2Data; nB2++; end
      if (txDValid)  begin lastD = txDData; nD++; end
    end
  end

  // ---------------- helpers ----------------
  logic [7:0] cfg[6];
  int tgt = 0;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    cfg[a] = d;
  endtask

  task automatic setCfg(input logic [7:0] t1, input logic [7:0] t2, input logic [7:0] r1,
                        input logic [7:0] r2, input logic [7:0] td, input logic [7:0] rd);
    wr(3'd0, t1); wr(3'd1, t2); wr(3'd2, r1); wr(3'd3, r2); wr(3'd4, td); wr(3'd5, rd);
    tgt = curFrame + 1;
  endtask

  task automatic waitDone(input int f);
    while (doneFrame < f) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [1:0] dExp(input int f, input int n);
    return {patBit(f, 2 * n), patBit(f, 2 * n + 1)};
  endfunction

  task automatic checkRx(input string tagOut, input string tagAct);
    int badOut = 0, badAct = 0;
    for (int k = 0; k < 512; k++) begin
      bit b1, b2, d, eEn, eD, eA;
      b1 = cfg[2][7] && (int'(cfg[2][5:0]) == k / 8);
      b2 = cfg[3][7] && (int'(cfg[3][5:0]) == k / 8);
      d  = rxDEnable && (int'(cfg[5]) == k / 2);
      eEn = b1 | b2 | d;
      eD = b1 ? lineRxB1[7 - k % 8] : b2 ? lineRxB2[7 - k % 8] : lineRxD[1 - k % 2];
      eA = !(b1 | b2);
      if (doneEn[k] != eEn || (eEn && doneD[k] != eD)) badOut++;
      if (doneA[k] != eA) badAct++;
    end
    chk(tagOut, badOut, 0, "serial output bit periods in error");
    chk(tagAct, badAct, 0, "slot-active bit periods in error");
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R6", serOutEn, 1'b0, "pad enable in reset");
    chk("R7", slotActiveN, 1'b1, "slot-active in reset");
    chk("R2", txB1Valid, 1'b0, "B1 strobe in reset");
    chk("R4", txDValid, 1'b0, "D strobe in reset");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    run = 1;
  endtask

  task automatic t_disabled();
    waitDone(2);
    chk("R3", lastB1, 8'hFF, "disabled tx B1 word");
    chk("R3", lastB2, 8'hFF, "disabled tx B2 word");
    chk("R3", (nB1 > 0), 1, "disabled tx B1 still strobes");
    chk("R4", lastD, 2'b11, "disabled tx D word");
    checkRx("R6", "R7");
  endtask

  task automatic t_tx_basic();
    txDEnable = 1'b1;
    setCfg(8'h80 | 8'd9, 8'h80 | 8'd63, 8'h00, 8'h00, 8'd200, 8'd0);
    waitDone(tgt);
    chk("R2", lastB1, patByte(tgt, 9), "tx B1 slot 9 word");
    chk("R1", lastB2, patByte(tgt, 63), "tx B2 last slot word");
    chk("R4", lastD, dExp(tgt, 200), "tx D sub-slot 200 word");
  endtask

  task automatic t_rx_basic();
    rxDEnable = 1'b1;
    setCfg(8'h80 | 8'd9, 8'h80 | 8'd63, 8'h80 | 8'd2, 8'h80 | 8'd60, 8'd200, 8'd7);
    waitDone(tgt);
    checkRx("R5", "R7");
    chk("R8", {doneEn[14], doneD[14], doneD[15]}, {1'b1, lineRxD}, "rx D sub-slot 7");
    chk("R7", doneA[14], 1'b1, "D sub-slot leaves slot-active high");
  endtask

  task automatic t_rx_disabled();
    rxDEnable = 1'b0;
    setCfg(8'h80 | 8'd9, 8'h80 | 8'd63, 8'h00 | 8'd2, 8'h80 | 8'd60, 8'd200, 8'd7);
    waitDone(tgt);
    checkRx("R6", "R7");
    chk("R6", doneEn[16], 1'b0, "disabled rx B1 slot undriven");
  endtask

  task automatic t_bit6();
    setCfg(8'hC0 | 8'd17, 8'h80 | 8'd63, 8'h40 | 8'd2, 8'h80 | 8'd60, 8'd200, 8'd7);
    waitDone(tgt);
    chk("R9", lastB1, patByte(tgt, 17), "bit 6 set on tx B1");
    checkRx("R9", "R9");
    chk("R9", doneEn[16], 1'b0, "bit 6 does not enable rx B1");
  endtask

  task automatic t_collision();
    logic [7:0] got;
    rxDEnable = 1'b1;
    setCfg(8'h80 | 8'd30, 8'h80 | 8'd30, 8'h80 | 8'd12, 8'h80 | 8'd12, 8'd200, 8'd7);
    waitDone(tgt);
    chk("R11", lastB1, patByte(tgt, 30), "shared slot tx B1");
    chk("R11", lastB2, patByte(tgt, 30), "shared slot tx B2");
    for (int i = 0; i < 8; i++) got[7 - i] = doneD[96 + i];
    chk("R11", got, lineRxB1, "B1 wins shared rx slot");
    checkRx("R11", "R7");
  endtask

  task automatic t_deferred();
    int f;
    setCfg(8'h80 | 8'd9, 8'h80 | 8'd63, 8'h80 | 8'd5, 8'h00, 8'd200, 8'd7);
    waitDone(tgt);
    while (curIdx < 100) @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd2; wrData = 8'h80 | 8'd40;
    @(negedge clk);
    wrEn = 1'b0;
    f = curFrame;
    waitDone(f);
    chk("R10", {doneEn[40], doneEn[320]}, 2'b10, "frame of write keeps old slot");
    cfg[2] = 8'h80 | 8'd40;
    waitDone(f + 1);
    chk("R10", {doneEn[40], doneEn[320]}, 2'b01, "next frame uses new slot");
    checkRx("R10", "R7");
  endtask

  task automatic t_resync();
    int f;
    jumpReq = 1;
    while (jumpReq) @(negedge clk);
    f = frameCnt;
    waitDone(f);
    chk("R1", lastB1, patByte(f, 9), "tx B1 after early sync");
    checkRx("R1", "R1");
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) cfg[i] = '0;
    t_reset();
    t_disabled();
    t_tx_basic();
    t_rx_basic();
    t_rx_disabled();
    t_bit6();
    t_collision();
    t_deferred();
    t_resync();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end
endmodule